// File: doc/BRIEF.md
# Eight-Channel Countdown Timer

This block holds eight independent 32-bit down-counters behind a word-wide register bus. Software reaches each counter through a 16-byte slot. A slot holds the live count, a reload value and two match words. A shared control word gives each counter a 4-bit nibble for run, clock source, overflow-interrupt enable and pulse mode. A second control word is stored and read back but drives nothing.

Counters do not run on clock edges directly. The chip supplies two tick-enable strobes: a slow one from an external reference and a fast one at the bus rate. Each counter steps once per strobe of the source it has selected. When a counter passes from one to zero, its interrupt line inverts level, and on its next tick it reloads and keeps counting. Software watches for edges on the line rather than a held level.

Read data is a combinational function of the address. Writes take effect on the clock edge on which `bus_we` is sampled high.

Top module: `octa_down_timer`

## Requirements
- R1: Slot base addresses are 0x00, 0x10 and 0x20 for channels 0 to 2, and (channel+1)*16 for channels 3 to 7. Within a slot the word offsets are: +0 count, +4 reload, +8 first match, +C second match. Offsets 0x38, 0x3C, anything above 0x8C and any address with bits [1:0] non-zero read as zero and ignore writes.
- R2: The control word at 0x30 reads back as written. The second control word at 0x34 also reads back as written and has no effect on any counter or output.
- R3: Channel i owns control bits [4i+3:4i], laid out as bit0 run, bit1 clock source, bit2 overflow interrupt, bit3 pulse. A running channel decrements by one per `tick_slow` strobe when bit1=1, and per `tick_fast` strobe when bit1=0. Strobes from the other source are ignored.
- R4: A running channel ticked at count 1 goes to 0 and inverts its `irq` bit, provided its overflow bit is set or either match word is zero. A running channel ticked at count 0 loads its reload value.
- R5: A match word accepts only a zero write, and a non-zero write leaves it unchanged. Because both match words are therefore always zero, an expiry inverts `irq` even with the overflow bit clear.
- R6: A write to the count word changes the live count only while that channel's run bit is set; otherwise the write is ignored.
- R7: A write to the reload word stores the value and also loads it into the live count.
- R8: A control write that clears a channel's run bit stops the channel and loads its count from the reload word in that same cycle. A tick in that same cycle is ignored, so neither the count nor `irq` steps.
- R9: A control write that sets a run bit leaves the count untouched in that cycle, even with a tick present. Counting starts from the next cycle on the newly selected source.
- R10: `pulse_mode[i]` is high only when channel i has its run and pulse bits both set and i is 4 or greater. For channels 0 to 3, the pulse bit is stored but has no effect.
- R11: After reset, both control words, all counts, reload and match words, `irq` and `pulse_mode` are zero.
- R12: While a channel's run bit is clear, its count and `irq` do not change on ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address of the word access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| tick_slow | input | 1 | Slow external tick-enable strobe |
| tick_fast | input | 1 | Bus-rate tick-enable strobe |
| irq | output | 8 | Per-channel interrupt level, inverted on each expiry |
| pulse_mode | output | 8 | Per-channel active pulse-mode flag |

## Verification
The bench aims at the split address map. If the decoder used a plain `offset>>4` for every slot, the reload writes to the upper channels would read back in the wrong slot, or the gap at 0x38 would alias a counter. It also aims at control writes that coincide with a tick. A design that applied the tick before the stop would leave the count one below the reload value, or would invert `irq` a second time. A design that started counting in the enable cycle would read one below the reload value at once. Further checks look for dropped effects:
- a count write on an idle channel that lands anyway;
- a non-zero match write that sticks;
- an interrupt that waits for the overflow bit;
- a pulse flag that rises on a lower channel.

// File: rtl/octtmr_pkg.sv
`timescale 1ns/1ps
package octtmr_pkg;
   // one control nibble, MSB first
   typedef struct packed {
      logic pulse;
      logic ovf_ie;
      logic ext_clk;
      logic run;
   } tmr_nib_t;

   typedef enum logic [1:0] {
      FLD_COUNT  = 2'd0,
      FLD_RELOAD = 2'd1,
      FLD_MATCHA = 2'd2,
      FLD_MATCHB = 2'd3
   } tmr_fld_e;
endpackage

// File: rtl/octtmr_decode.sv
`timescale 1ns/1ps
module octtmr_decode #(
   parameter int NUM_CH = 8,
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              ch_hit,
   output logic [3:0]        ch_sel,
   output logic [1:0]        fld,
   output logic              ctrl_hit,
   output logic              ctrl2_hit
);
   localparam int LOW_SLOTS = 3;   // slots below the control word
   localparam int CTRL_SLOT = 3;

   logic       upper_zero;
   logic [3:0] slot;

   generate
      if (ADDR_W > 8) begin : g_wide
         assign upper_zero = (addr[ADDR_W-1:8] == '0);
      end else begin : g_narrow
         assign upper_zero = 1'b1;
      end
   endgenerate

   assign slot = addr[7:4];
   assign fld  = addr[3:2];

   always_comb begin
      ch_hit    = 1'b0;
      ch_sel    = '0;
      ctrl_hit  = 1'b0;
      ctrl2_hit = 1'b0;
      if (upper_zero && addr[1:0] == 2'b00) begin
         if (int'(slot) < LOW_SLOTS) begin
            ch_hit = 1'b1;
            ch_sel = slot;
         end else if (int'(slot) == CTRL_SLOT) begin
            ctrl_hit  = (fld == 2'd0);
            ctrl2_hit = (fld == 2'd1);
         end else if (int'(slot) <= NUM_CH) begin
            ch_hit = 1'b1;
            ch_sel = slot - 4'd1;
         end
      end
   end
endmodule

// File: rtl/octtmr_chan.sv
`timescale 1ns/1ps
module octtmr_chan #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_q,
   input  logic          ext_q,
   input  logic          ovf_q,
   input  logic          ctrl_wr,
   input  logic          run_d,
   input  logic          tick_slow,
   input  logic          tick_fast,
   input  logic          wr_cnt,
   input  logic          wr_rld,
   input  logic          wr_ma,
   input  logic          wr_mb,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] cnt,
   output logic [DW-1:0] rld,
   output logic [DW-1:0] ma,
   output logic [DW-1:0] mb,
   output logic          irq
);
   logic tick, stop, qual;

   assign tick = ext_q ? tick_slow : tick_fast;
   assign stop = ctrl_wr & run_q & ~run_d;
   assign qual = ovf_q | (ma == '0) | (mb == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         rld <= '0;
         ma  <= '0;
         mb  <= '0;
         irq <= 1'b0;
      end else begin
         if (wr_ma && wdata == '0) ma <= wdata;
         if (wr_mb && wdata == '0) mb <= wdata;
         if (wr_rld) rld <= wdata;
         if (stop) begin
            cnt <= rld;
         end else if (wr_rld) begin
            cnt <= wdata;
         end else if (wr_cnt && run_q) begin
            cnt <= wdata;
         end else if (run_q && tick) begin
            if (cnt == '0) begin
               cnt <= rld;
            end else begin
               cnt <= cnt - 1'b1;
               if (cnt == DW'(1) && qual) irq <= ~irq;
            end
         end
      end
   end
endmodule

// File: rtl/octa_down_timer.sv
`timescale 1ns/1ps
module octa_down_timer #(
   parameter int NUM_CH      = 8,
   parameter int DW          = 32,
   parameter int ADDR_W      = 12,
   parameter int PULSE_FIRST = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   input  logic              tick_slow,
   input  logic              tick_fast,
   output logic [NUM_CH-1:0] irq,
   output logic [NUM_CH-1:0] pulse_mode
);
   import octtmr_pkg::*;

   localparam int NIB_W  = 4;
   localparam int CTRL_W = NUM_CH * NIB_W;

   generate
      if (NUM_CH < 4 || NUM_CH > 8) begin : g_bad_ch
         $error("NUM_CH must lie in 4..8");
      end
      if (DW < CTRL_W) begin : g_bad_dw
         $error("DW must hold every control nibble");
      end
      if (ADDR_W < 8) begin : g_bad_aw
         $error("ADDR_W must cover the register window");
      end
   endgenerate

   logic                        ch_hit, ctrl_hit, ctrl2_hit;
   logic [3:0]                  ch_sel;
   logic [1:0]                  fld;
   logic [CTRL_W-1:0]           ctrl_q;
   logic [DW-1:0]               ctrl2_q;
   logic                        ctrl_wr;
   logic [NUM_CH-1:0][DW-1:0]   cnt_v, rld_v, ma_v, mb_v;
   tmr_nib_t                    nib_q [NUM_CH];
   tmr_nib_t                    nib_d [NUM_CH];

   octtmr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dec_i (
      .addr(bus_addr), .ch_hit(ch_hit), .ch_sel(ch_sel), .fld(fld),
      .ctrl_hit(ctrl_hit), .ctrl2_hit(ctrl2_hit)
   );

   assign ctrl_wr = bus_we & ctrl_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         ctrl2_q <= '0;
      end else begin
         if (ctrl_wr) ctrl_q <= bus_wdata[CTRL_W-1:0];
         if (bus_we && ctrl2_hit) ctrl2_q <= bus_wdata;
      end
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic here;
      assign nib_q[i] = tmr_nib_t'(ctrl_q[i*NIB_W +: NIB_W]);
      assign nib_d[i] = tmr_nib_t'(bus_wdata[i*NIB_W +: NIB_W]);
      assign here     = bus_we & ch_hit & (ch_sel == 4'(i));

      octtmr_chan #(.DW(DW)) chan_i (
         .clk(clk), .rst_n(rst_n),
         .run_q(nib_q[i].run), .ext_q(nib_q[i].ext_clk), .ovf_q(nib_q[i].ovf_ie),
         .ctrl_wr(ctrl_wr), .run_d(nib_d[i].run),
         .tick_slow(tick_slow), .tick_fast(tick_fast),
         .wr_cnt(here && tmr_fld_e'(fld) == FLD_COUNT),
         .wr_rld(here && tmr_fld_e'(fld) == FLD_RELOAD),
         .wr_ma(here && tmr_fld_e'(fld) == FLD_MATCHA),
         .wr_mb(here && tmr_fld_e'(fld) == FLD_MATCHB),
         .wdata(bus_wdata),
         .cnt(cnt_v[i]), .rld(rld_v[i]), .ma(ma_v[i]), .mb(mb_v[i]),
         .irq(irq[i])
      );

      if (i >= PULSE_FIRST) begin : g_pulse
         assign pulse_mode[i] = nib_q[i].run & nib_q[i].pulse;
      end else begin : g_no_pulse
         assign pulse_mode[i] = 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (ctrl_hit) begin
         bus_rdata = DW'(ctrl_q);
      end else if (ctrl2_hit) begin
         bus_rdata = ctrl2_q;
      end else if (ch_hit) begin
         for (int k = 0; k < NUM_CH; k++) begin
            if (ch_sel == 4'(k)) begin
               case (tmr_fld_e'(fld))
                  FLD_COUNT:  bus_rdata = cnt_v[k];
                  FLD_RELOAD: bus_rdata = rld_v[k];
                  FLD_MATCHA: bus_rdata = ma_v[k];
                  default:    bus_rdata = mb_v[k];
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/octtmr_chk.sv
`timescale 1ns/1ps
module octtmr_chk #(
   parameter int NUM_CH = 8,
   parameter int DW     = 32,
   parameter int ADDR_W = 12
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [ADDR_W-1:0]         bus_addr,
   input logic                      bus_we,
   input logic [DW-1:0]             bus_wdata,
   input logic [DW-1:0]             bus_rdata,
   input logic [NUM_CH-1:0]         irq,
   input logic [NUM_CH*4-1:0]       ctrl_q,
   input logic [NUM_CH-1:0][DW-1:0] cnt_v,
   input logic [NUM_CH-1:0][DW-1:0] rld_v
);
   logic wr_ctrl;
   assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(12'h030));

   AST_GAP_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(12'h038) || bus_addr == ADDR_W'(12'h03C)) |-> bus_rdata == '0); // R1

   for (genvar i = 0; i < NUM_CH; i++) begin : g_a
      localparam logic [ADDR_W-1:0] BASE = ADDR_W'((i < 3) ? i * 16 : (i + 1) * 16);

      AST_IDLE_IRQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
         !ctrl_q[4*i] |=> $stable(irq[i])); // R12

      AST_TOGGLE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(irq[i]) |-> cnt_v[i] == '0); // R4

      AST_STOP_LOADS_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_ctrl && ctrl_q[4*i] && !bus_wdata[4*i]) |=> cnt_v[i] == $past(rld_v[i])); // R8

      AST_IDLE_COUNT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_we && bus_addr == BASE && !ctrl_q[4*i]) |=> $stable(cnt_v[i])); // R6

      AST_MATCH_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_addr == BASE + ADDR_W'(8) || bus_addr == BASE + ADDR_W'(12)) |-> bus_rdata == '0); // R5
   end
endmodule

bind octa_down_timer octtmr_chk #(.NUM_CH(NUM_CH), .DW(DW), .ADDR_W(ADDR_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
   .ctrl_q(ctrl_q), .cnt_v(cnt_v), .rld_v(rld_v)
);

// File: tb/octa_down_timer_tb_top.sv
`timescale 1ns/1ps
module octa_down_timer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [11:0] bus_addr;
   logic        bus_we;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic        tick_slow, tick_fast;
   logic [7:0]  irq, pulse_mode;
   int          checks = 0;
   int          errors = 0;
   bit          done   = 1'b0;

   always #2.5 clk = ~clk;

   octa_down_timer dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_slow(tick_slow),
      .tick_fast(tick_fast), .irq(irq), .pulse_mode(pulse_mode)
   );

   function automatic logic [11:0] base(input int ch);
      return 12'((ch < 3) ? ch * 16 : (ch + 1) * 16);
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
      end
   endtask

   task automatic wr_t(input logic [11:0] a, input logic [31:0] d, input bit f, input bit s);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d; tick_fast = f; tick_slow = s;
      @(negedge clk);
      bus_we = 1'b0; tick_fast = 1'b0; tick_slow = 1'b0;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      wr_t(a, d, 1'b0, 1'b0);
   endtask

   task automatic rd_chk(input string req, input string what, input logic [11:0] a, input logic [31:0] exp);
      @(negedge clk);
      bus_addr = a;
      #1;
      chk(req, what, bus_rdata, exp);
   endtask

   task automatic ticks(input bit fast, input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (fast) tick_fast = 1'b1; else tick_slow = 1'b1;
         @(negedge clk);
         tick_fast = 1'b0; tick_slow = 1'b0;
      end
   endtask

   task automatic t_reset;
      rd_chk("R11", "ctrl after reset", 12'h030, 32'h0);
      rd_chk("R11", "ctrl2 after reset", 12'h034, 32'h0);
      rd_chk("R11", "ch0 count after reset", base(0), 32'h0);
      rd_chk("R11", "ch7 reload after reset", base(7) + 12'h4, 32'h0);
      chk("R11", "irq after reset", 32'(irq), 32'h0);
      chk("R11", "pulse_mode after reset", 32'(pulse_mode), 32'h0);
   endtask

   task automatic t_map;
      for (int c = 0; c < 8; c++) wr(base(c) + 12'h4, 32'h100 + 32'(c));
      for (int c = 0; c < 8; c++) begin
         rd_chk("R1", $sformatf("ch%0d reload slot", c), base(c) + 12'h4, 32'h100 + 32'(c));
         rd_chk("R7", $sformatf("ch%0d count from reload", c), base(c), 32'h100 + 32'(c));
      end
      wr(12'h038, 32'hFFFF_FFFF);
      wr(12'h03C, 32'hFFFF_FFFF);
      wr(12'h031, 32'hFFFF_FFFF);
      rd_chk("R1", "gap 0x38 reads zero", 12'h038, 32'h0);
      rd_chk("R1", "gap 0x3C reads zero", 12'h03C, 32'h0);
      rd_chk("R1", "0x90 reads zero", 12'h090, 32'h0);
      rd_chk("R1", "misaligned read zero", 12'h005, 32'h0);
      rd_chk("R1", "ctrl untouched by bad writes", 12'h030, 32'h0);
      wr(12'h034, 32'hDEAD_BEEF);
      rd_chk("R2", "ctrl2 readback", 12'h034, 32'hDEAD_BEEF);
      ticks(1'b1, 2);
      rd_chk("R2", "ctrl2 has no effect on ch0", base(0), 32'h100);
      chk("R2", "ctrl2 has no effect on irq", 32'(irq), 32'h0);
   endtask

   task automatic t_idle;
      wr(base(2) + 12'hC, 32'h5);
      rd_chk("R5", "nonzero match B rejected", base(2) + 12'hC, 32'h0);
      wr(base(2) + 12'h8, 32'h7);
      rd_chk("R5", "nonzero match A rejected", base(2) + 12'h8, 32'h0);
      wr(base(1), 32'h55);
      rd_chk("R6", "count write ignored while idle", base(1), 32'h101);
      ticks(1'b1, 3);
      rd_chk("R12", "idle ch1 holds on ticks", base(1), 32'h101);
      chk("R12", "idle irq steady", 32'(irq), 32'h0);
   endtask

   task automatic t_run_fast;
      wr(base(0) + 12'h4, 32'h3);
      wr_t(12'h030, 32'h1, 1'b1, 1'b0);
      rd_chk("R9", "no step in enable cycle", base(0), 32'h3);
      rd_chk("R2", "ctrl readback", 12'h030, 32'h1);
      ticks(1'b1, 2);
      rd_chk("R3", "fast ticks decrement", base(0), 32'h1);
      chk("R4", "irq before expiry", 32'(irq), 32'h0);
      ticks(1'b1, 1);
      rd_chk("R4", "count at zero", base(0), 32'h0);
      chk("R5", "expiry toggles with overflow bit clear", 32'(irq), 32'h1);
      ticks(1'b1, 1);
      rd_chk("R4", "reload after zero", base(0), 32'h3);
      chk("R4", "irq held after reload", 32'(irq), 32'h1);
      ticks(1'b0, 2);
      rd_chk("R3", "slow ticks ignored on fast source", base(0), 32'h3);
      wr(base(0), 32'h2);
      rd_chk("R6", "count write while running", base(0), 32'h2);
      ticks(1'b1, 2);
      chk("R4", "second expiry toggles back", 32'(irq), 32'h0);
   endtask

   task automatic t_slow_stop;
      wr(base(5) + 12'h4, 32'h2);
      wr(12'h030, 32'h00B0_0090);
      rd_chk("R8", "ch0 stop loads reload", base(0), 32'h3);
      chk("R10", "pulse only on upper channel", 32'(pulse_mode), 32'h20);
      ticks(1'b1, 2);
      rd_chk("R3", "fast ticks ignored on slow source", base(5), 32'h2);
      rd_chk("R3", "ch1 runs on fast", base(1), 32'hFF);
      rd_chk("R12", "stopped ch0 holds", base(0), 32'h3);
      ticks(1'b0, 2);
      rd_chk("R4", "ch5 at zero", base(5), 32'h0);
      chk("R4", "ch5 irq toggled", 32'(irq), 32'h20);
      ticks(1'b0, 2);
      rd_chk("R3", "ch5 reloaded then stepped", base(5), 32'h1);
      wr_t(12'h030, 32'h0000_0090, 1'b0, 1'b1);
      rd_chk("R8", "stop wins over coincident tick", base(5), 32'h2);
      chk("R8", "no toggle on stop cycle", 32'(irq), 32'h20);
      chk("R10", "pulse drops with run", 32'(pulse_mode), 32'h0);
      ticks(1'b0, 3);
      rd_chk("R12", "stopped ch5 holds", base(5), 32'h2);
      chk("R12", "stopped irq steady", 32'(irq), 32'h20);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
      tick_slow = 1'b0; tick_fast = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_map;
      t_idle;
      t_run_fast;
      t_slow_stop;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule